// File: doc/BRIEF.md
# Maskable Sticky Interrupt Status Unit

This unit keeps an eight-bit interrupt status register, an eight-bit enable mask, and one level-sensitive interrupt line for a packet-buffer network controller. Two kinds of source set status bits. Single-cycle strobes come from the buffer allocator and the receive path. Levels describing queue state set their bits again on every clock for as long as the level is high. Once set, a bit stays set until something explicitly clears it. A bit can be cleared in three ways: by a host acknowledge write, by a receive-queue pop that leaves the queue empty, or by a new allocation command.

The host reaches the unit through a byte write port and a byte read port. The write port selects either the acknowledge register or the mask register. The read port returns either the status or the mask. The unit does no bus decoding and holds no queue storage. Queue state arrives as input levels. Acknowledging the transmit-done bit sends one pop strobe back to the transmit-done queue. Software uses the usual sequence: enable sources in the mask, take the interrupt, read status, then acknowledge.

Top module: `irq_status_unit`

## Requirements
- R1: In a reset cycle the status register loads 0x04, with only the transmit-empty bit set, and the mask loads 0x00. The interrupt output is then low.
- R2: Status bit 2 (transmit empty) is set on every clock edge at which `tx_idle_i` is high.
- R3: Status bit 1 (transmit done) is set on every clock edge at which `done_nonempty_i` is high.
- R4: An acknowledge write (`wr_sel_i`=0) of byte V clears the status bits given by V AND 0xD6, so only bits 7, 6, 4, 2 and 1 can be cleared this way. Bits 5, 3 and 0 are unaffected.
- R5: `done_pop_o` is high in the same cycle as an acknowledge write whose data bit 1 is set, and low otherwise.
- R6: If a set condition and any clear hit the same bit on the same clock edge, the bit ends up set.
- R7: `irq_o` is high exactly when status AND mask is nonzero.
- R8: A receive-queue pop (`rx_pop_i`) sets status bit 0 when `rx_left_i` says entries remain. It clears bit 0 when the queue is now empty.
- R9: A received-frame strobe (`rx_frame_i`) sets status bit 0.
- R10: `alloc_ok_i` sets status bit 3. `alloc_cmd_i` clears status bit 3. Acknowledge writes do not clear bit 3.
- R11: A mask write (`wr_sel_i`=1) stores the whole byte. `rd_sel_i`=1 reads the mask back, and `rd_sel_i`=0 reads the status.
- R12: Each `aux_evt_i` strobe bit sets exactly one status bit: bit 0 sets receive overrun (status 4), bit 1 sets the link-status event (status 5), bit 2 sets early receive (status 6), and bit 3 sets management (status 7). Status bit 5 is cleared only by reset.

Status bit order, from bit 7 down to bit 0: management, early receive, link-status event, receive overrun, allocation done, transmit empty, transmit done, receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_evt_i | input | 4 | Strobes that set status bits 4 to 7 |
| alloc_ok_i | input | 1 | Strobe: a buffer allocation succeeded |
| alloc_cmd_i | input | 1 | Strobe: a new allocation command was issued |
| rx_frame_i | input | 1 | Strobe: a frame was stored in the receive queue |
| rx_pop_i | input | 1 | Strobe: one receive-queue entry was removed |
| rx_left_i | input | 1 | Receive queue not empty after the pop |
| tx_idle_i | input | 1 | Level: pending transmit queue is empty |
| done_nonempty_i | input | 1 | Level: transmit-done queue holds entries |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 1 | Write target: 0 acknowledge, 1 mask |
| wr_data_i | input | 8 | Host write byte |
| rd_sel_i | input | 1 | Read source: 0 status, 1 mask |
| rd_data_o | output | 8 | Selected register value |
| irq_o | output | 1 | Level interrupt request |
| done_pop_o | output | 1 | Pop strobe to the transmit-done queue |

## Verification
Status and mask are registers. A strobe, level or write applied before a clock edge therefore shows up on `rd_data_o` and `irq_o` one edge later, and the bench reads them at the falling edge that follows. `done_pop_o` is a combinational function of the write port, so the bench samples it inside the cycle in which the acknowledge is driven, before the edge. The bench drives inputs only at falling edges, which keeps every expected value one cycle or zero cycles away from its stimulus.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
    localparam int STAT_W = 8;

    localparam int B_RCV     = 0;
    localparam int B_TXDONE  = 1;
    localparam int B_TXEMPTY = 2;
    localparam int B_ALLOC   = 3;
    localparam int B_OVRN    = 4;
    localparam int B_LINK    = 5;
    localparam int B_ERX     = 6;
    localparam int B_MGMT    = 7;
    localparam int AUX_W     = STAT_W - B_OVRN;

    localparam logic [STAT_W-1:0] ACK_MASK   = 8'hD6;
    localparam logic [STAT_W-1:0] RESET_STAT = 8'h04;
    localparam logic [STAT_W-1:0] RESET_MASK = 8'h00;

    typedef enum logic {
        REG_ACK  = 1'b0,
        REG_MASK = 1'b1
    } wr_target_e;

    typedef struct packed {
        logic [STAT_W-1:0] set;
        logic [STAT_W-1:0] clr;
    } stat_upd_t;

    function automatic logic [STAT_W-1:0] apply_upd(input logic [STAT_W-1:0] cur,
                                                    input stat_upd_t upd);
        return (cur & ~upd.clr) | upd.set;
    endfunction
endpackage

// File: rtl/irqs_event_map.sv
module irqs_event_map
    import irqs_pkg::*;
(
    input  logic [AUX_W-1:0]  aux_evt,
    input  logic              alloc_ok,
    input  logic              alloc_cmd,
    input  logic              rx_frame,
    input  logic              rx_pop,
    input  logic              rx_left,
    input  logic              tx_idle,
    input  logic              done_nonempty,
    input  logic              ack_wr,
    input  logic [STAT_W-1:0] ack_data,
    output stat_upd_t         upd
);
    logic [STAT_W-1:0] set_v;
    logic [STAT_W-1:0] clr_v;

    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[B_RCV]     = rx_frame | (rx_pop & rx_left);
        set_v[B_TXDONE]  = done_nonempty;
        set_v[B_TXEMPTY] = tx_idle;
        set_v[B_ALLOC]   = alloc_ok;
        for (int k = 0; k < AUX_W; k++) begin
            set_v[B_OVRN + k] = aux_evt[k];
        end
        if (ack_wr) begin
            clr_v = ack_data & ACK_MASK;
        end
        if (rx_pop && !rx_left) begin
            clr_v[B_RCV] = 1'b1;
        end
        if (alloc_cmd) begin
            clr_v[B_ALLOC] = 1'b1;
        end
    end

    assign upd.set = set_v;
    assign upd.clr = clr_v;
endmodule

// File: rtl/irqs_status_reg.sv
module irqs_status_reg
    import irqs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  stat_upd_t         upd,
    output logic [STAT_W-1:0] stat_q
);
    logic [STAT_W-1:0] stat_d;

    assign stat_d = apply_upd(stat_q, upd);

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[i] <= RESET_STAT[i];
            end else begin
                stat_q[i] <= stat_d[i];
            end
        end

        assert_set_wins_R6 : assert property (@(posedge clk) disable iff (rst)
            upd.set[i] |=> stat_q[i]);
    end

    assert_reset_value_R1 : assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat_q == RESET_STAT));

    assert_link_sticky_R12 : assert property (@(posedge clk) disable iff (rst)
        stat_q[B_LINK] |=> stat_q[B_LINK]);
endmodule

// File: rtl/irqs_mask_reg.sv
module irqs_mask_reg
    import irqs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= RESET_MASK;
        end else if (mask_wr) begin
            mask_q <= wr_data;
        end
    end

    assert_mask_store_R11 : assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> (mask_q == $past(wr_data)));

    assert_mask_hold_R11 : assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask_q));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irqs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [AUX_W-1:0]  aux_evt_i,
    input  logic              alloc_ok_i,
    input  logic              alloc_cmd_i,
    input  logic              rx_frame_i,
    input  logic              rx_pop_i,
    input  logic              rx_left_i,
    input  logic              tx_idle_i,
    input  logic              done_nonempty_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [STAT_W-1:0] wr_data_i,
    input  logic              rd_sel_i,
    output logic [STAT_W-1:0] rd_data_o,
    output logic              irq_o,
    output logic              done_pop_o
);
    wr_target_e        tgt;
    logic              ack_wr;
    logic              mask_wr;
    stat_upd_t         upd;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] mask_q;

    assign tgt     = wr_target_e'(wr_sel_i);
    assign ack_wr  = wr_en_i && (tgt == REG_ACK);
    assign mask_wr = wr_en_i && (tgt == REG_MASK);

    irqs_event_map u_map (
        .aux_evt       (aux_evt_i),
        .alloc_ok      (alloc_ok_i),
        .alloc_cmd     (alloc_cmd_i),
        .rx_frame      (rx_frame_i),
        .rx_pop        (rx_pop_i),
        .rx_left       (rx_left_i),
        .tx_idle       (tx_idle_i),
        .done_nonempty (done_nonempty_i),
        .ack_wr        (ack_wr),
        .ack_data      (wr_data_i),
        .upd           (upd)
    );

    irqs_status_reg u_stat (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .stat_q (stat_q)
    );

    irqs_mask_reg u_mask (
        .clk     (clk),
        .rst     (rst),
        .mask_wr (mask_wr),
        .wr_data (wr_data_i),
        .mask_q  (mask_q)
    );

    assign irq_o      = |(stat_q & mask_q);
    assign done_pop_o = ack_wr && wr_data_i[B_TXDONE];
    assign rd_data_o  = rd_sel_i ? mask_q : stat_q;

    // R4: an acknowledge never drops a bit outside the clearable set
    assert_ack_scope_R4 : assert property (@(posedge clk) disable iff (rst)
        (ack_wr && !rx_pop_i && !alloc_cmd_i)
        |=> (($past(stat_q) & ~ACK_MASK & ~stat_q) == '0));

    assert_rx_empty_clear_R8 : assert property (@(posedge clk) disable iff (rst)
        (rx_pop_i && !rx_left_i && !rx_frame_i) |=> !stat_q[B_RCV]);

    assert_alloc_clear_R10 : assert property (@(posedge clk) disable iff (rst)
        (alloc_cmd_i && !alloc_ok_i) |=> !stat_q[B_ALLOC]);

    assert_irq_low_after_reset_R1 : assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_o);
endmodule

// File: tb/irq_status_unit_tb_top.sv
module irq_status_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] aux_evt = '0;
    logic       alloc_ok = 0, alloc_cmd = 0, rx_frame = 0, rx_pop = 0, rx_left = 0;
    logic       tx_idle = 0, done_ne = 0, wr_en = 0, wr_sel = 0, rd_sel = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq, done_pop;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 0;

    always #10 clk = ~clk;

    irq_status_unit dut_i (
        .clk(clk), .rst(rst), .aux_evt_i(aux_evt), .alloc_ok_i(alloc_ok),
        .alloc_cmd_i(alloc_cmd), .rx_frame_i(rx_frame), .rx_pop_i(rx_pop),
        .rx_left_i(rx_left), .tx_idle_i(tx_idle), .done_nonempty_i(done_ne),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_o(irq), .done_pop_o(done_pop)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_stat(input string req, input logic [7:0] exp);
        rd_sel = 1'b0;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic read_mask(input string req, input logic [7:0] exp);
        rd_sel = 1'b1;
        #1;
        chk(req, rd_data, exp);
        rd_sel = 1'b0;
    endtask

    task automatic fill_all();
        aux_evt = 4'hF; alloc_ok = 1; rx_frame = 1; tx_idle = 1; done_ne = 1;
        step();
        aux_evt = '0; alloc_ok = 0; rx_frame = 0; tx_idle = 0; done_ne = 0;
    endtask

    task automatic ack(input logic [7:0] v);
        wr_en = 1; wr_sel = 0; wr_data = v;
        #1;
        chk("R5 pop strobe", {7'd0, done_pop}, {7'd0, v[1]});
        step();
        wr_en = 0;
    endtask

    task automatic wr_mask(input logic [7:0] v);
        wr_en = 1; wr_sel = 1; wr_data = v;
        step();
        wr_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (2) step();
        // R1 reset state
        read_stat("R1 status", 8'h04);
        read_mask("R1 mask", 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rst = 0;
        step();
        read_stat("R1 sticky after reset", 8'h04);

        // R4/R5 acknowledge sweep
        for (int v = 0; v < 256; v++) begin
            fill_all();
            ack(v[7:0]);
            read_stat("R4 ack sweep", 8'hFF & ~(v[7:0] & 8'hD6));
        end

        // R6/R2/R3 set wins over acknowledge
        fill_all();
        tx_idle = 1;
        ack(8'hD6);
        read_stat("R6 tx empty level vs ack", 8'h2D);
        tx_idle = 0; done_ne = 1;
        ack(8'hD6);
        read_stat("R6 tx done level vs ack", 8'h2B);
        done_ne = 0;
        ack(8'hFF);
        read_stat("R4 unclearable remain", 8'h29);
        done_ne = 1; step(); done_ne = 0;
        read_stat("R3 done level", 8'h2B);
        tx_idle = 1; step(); tx_idle = 0;
        read_stat("R2 empty level", 8'h2F);
        ack(8'h06);
        read_stat("R4 clear tx bits", 8'h29);

        // R8/R9 receive bit
        rx_pop = 1; rx_left = 1; step();
        read_stat("R8 pop entries remain", 8'h29);
        rx_left = 0; step();
        read_stat("R8 pop now empty", 8'h28);
        rx_frame = 1; step(); rx_frame = 0;
        read_stat("R6 pop-empty with frame", 8'h29);
        step(); rx_pop = 0;
        read_stat("R8 pop clears again", 8'h28);
        rx_frame = 1; step(); rx_frame = 0;
        read_stat("R9 frame sets", 8'h29);

        // R10 allocation bit
        alloc_cmd = 1; step(); alloc_cmd = 0;
        read_stat("R10 cmd clears", 8'h21);
        alloc_ok = 1; step(); alloc_ok = 0;
        read_stat("R10 ok sets", 8'h29);
        alloc_cmd = 1; alloc_ok = 1; step(); alloc_cmd = 0; alloc_ok = 0;
        read_stat("R6 cmd and ok together", 8'h29);
        ack(8'h08);
        read_stat("R10 ack cannot clear", 8'h29);

        // R12 auxiliary strobes
        rst = 1; step(); rst = 0;
        read_stat("R1 soft reset", 8'h04);
        ack(8'h04);
        read_stat("R4 clear empty", 8'h00);
        for (int k = 0; k < 4; k++) begin
            aux_evt = 4'(1 << k); step(); aux_evt = '0;
            read_stat("R12 aux strobe", 8'((8'h10 << k) - 8'h10) | 8'(8'h10 << k));
        end
        ack(8'hFF);
        read_stat("R12 link bit kept", 8'h20);

        // R11/R7 mask sweep against status 0x29
        fill_all();
        ack(8'hD6);
        for (int m = 0; m < 256; m++) begin
            wr_mask(m[7:0]);
            read_mask("R11 mask readback", m[7:0]);
            read_stat("R11 status unaffected", 8'h29);
            chk("R7 irq", {7'd0, irq}, {7'd0, |(m[7:0] & 8'h29)});
        end
        wr_mask(8'h02);
        chk("R7 irq masked off", {7'd0, irq}, 8'h00);
        done_ne = 1; step(); done_ne = 0;
        chk("R7 irq raised by level", {7'd0, irq}, 8'h01);
        ack(8'h02);
        chk("R7 irq dropped after ack", {7'd0, irq}, 8'h00);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule